// File: doc/BRIEF.md
# Channel-to-Synthesizer Programming Sequencer

This block sits on the controller side of a frequency synthesizer. A request carries a channel frequency in MHz, a flag that selects receive or transmit, and a reference divider value. The block works out the local-oscillator frequency, splits it into a prescaler count N and a swallow count A, and sends two serial words over a three-wire bus made of a clock, a data line and a load strobe. Each word is followed by a strobe pulse. The reference word goes first and the divider word second.

Requests arrive on a valid/ready interface. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low for the whole programming sequence. A request that is offered while ready is low and then withdrawn has no effect. A request whose fields cannot be encoded is answered with a one-cycle `reject` pulse, and nothing is sent on the bus. `busy` and a one-cycle `done` report the progress of an accepted request.

The serial clock half-period and the strobe width are parameters counted in system-clock cycles. With a 125 MHz system clock, the defaults give a 7.8125 MHz serial clock and a strobe of 104 ns.

Top module: `synth_prog_seq`

## Requirements
- R1: `req_ready` is high exactly when no sequence is in progress, and that includes the cycles of reset. A request is accepted only on a rising clock edge where both `req_valid` and `req_ready` are high. A `req_valid` that is raised and dropped while `req_ready` is low produces no bus activity.
- R2: A reference value outside 5..20 is rejected. The block raises `reject` for exactly one cycle, in the cycle after the accepting edge, and stays idle with no bus activity.
- R3: When `req_rx` is 1, the oscillator frequency is the channel minus 2 MHz. When it is 0, the oscillator frequency is the channel itself. A receive request whose channel is below 2 is rejected as in R2.
- R4: N is the oscillator frequency divided by 32 and A is the remainder, so the oscillator frequency equals 32·N + A.
- R5: The reference word is sent first. It is 6 bits, a control bit of 1 followed by R[4:0]. The divider word follows. It is 13 bits, a control bit of 0 followed by N[6:0] and then A[4:0]. Both words are sent MSB first.
- R6: The serial clock is low whenever the block is idle. Within a word, every low and every high half-period lasts `HALF_DIV` system cycles.
- R7: The data line changes only while the serial clock is low. It holds steady through every cycle in which the clock is high.
- R8: The strobe `syn_le` rises at the edge where the clock falls after a word's last rising edge. It stays high for `LE_CYCLES` system cycles, and the clock stays low for that whole time.
- R9: `busy` is high from the cycle after acceptance until the second strobe ends. That span is 38·`HALF_DIV` + 2·`LE_CYCLES` cycles. `done` is high for the single cycle that follows, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_chan_mhz | input | 12 | Channel frequency in MHz |
| req_rx | input | 1 | 1 = receive (oscillator offset by the intermediate frequency) |
| req_ref | input | 5 | Reference divider value |
| syn_sclk | output | 1 | Serial programming clock |
| syn_sdata | output | 1 | Serial programming data |
| syn_le | output | 1 | Load strobe after each word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| reject | output | 1 | One-cycle pulse when a request cannot be encoded |

## Verification
The assertions assume that reset is held low for at least one clock before operation. They also assume that request fields are stable in any cycle where `req_valid` is high, because the divider split is checked at the accepting edge. The stimulus drives every input one time unit after a rising edge and holds each request for exactly one accepting edge. It waits for `req_ready` before it offers a request, except in the deliberate busy-time pulse, which the R1 check is built to exercise.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int REF_W      = 5;
  localparam int N_W        = 7;
  localparam int A_W        = 5;
  localparam int REF_WORD_W = REF_W + 1;
  localparam int DIV_WORD_W = N_W + A_W + 1;
  localparam int WORD_MAX   = DIV_WORD_W;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SHIFT,
    SEQ_STROBE
  } seq_state_e;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
  } div_pair_t;

  // Reference word, left aligned in the shared shift width.
  function automatic logic [WORD_MAX-1:0] make_ref_word(input logic [REF_W-1:0] r);
    return {1'b1, r, {(WORD_MAX-REF_WORD_W){1'b0}}};
  endfunction

  function automatic logic [WORD_MAX-1:0] make_div_word(input div_pair_t d);
    return {1'b0, d.n, d.a};
  endfunction
endpackage

// File: rtl/sps_divcalc.sv
module sps_divcalc
  import sps_pkg::*;
#(
  parameter int FREQ_W  = 12,
  parameter int IF_MHZ  = 2,
  parameter int REF_MIN = 5,
  parameter int REF_MAX = 20
) (
  input  logic [FREQ_W-1:0] chan,
  input  logic              rx,
  input  logic [REF_W-1:0]  ref_val,
  output div_pair_t         pair,
  output logic              ok
);
  logic [FREQ_W-1:0] lo_freq;
  logic [FREQ_W-1:0] quot;
  logic              under;
  logic              ref_ok;
  logic              n_fit;

  always_comb begin
    under   = rx && (chan < FREQ_W'(IF_MHZ));
    lo_freq = rx ? (chan - FREQ_W'(IF_MHZ)) : chan;
    quot    = lo_freq >> A_W;
    n_fit   = (quot >> N_W) == '0;
    ref_ok  = (ref_val >= REF_W'(REF_MIN)) && (ref_val <= REF_W'(REF_MAX));
    ok      = ref_ok && !under && n_fit;
    pair.n  = quot[N_W-1:0];
    pair.a  = lo_freq[A_W-1:0];
  end
endmodule

// File: rtl/sps_tick.sv
module sps_tick #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (en)     cnt <= tick ? '0 : cnt + 1'b1;
  end

  AST_TICK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HALF_DIV - 1)); // R6
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter #(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [$clog2(WORD_W+1)-1:0] load_len,
  input  logic              step,
  output logic              sclk,
  output logic              sdata,
  output logic              last_fall
);
  localparam int LW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sreg;
  logic [LW-1:0]     left;
  logic              phase;

  assign sclk      = phase;
  assign sdata     = sreg[WORD_W-1];
  assign last_fall = step && phase && (left == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      left  <= '0;
      phase <= 1'b0;
    end else if (load) begin
      sreg  <= load_word;
      left  <= load_len;
      phase <= 1'b0;
    end else if (step && (left != '0)) begin
      if (!phase) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        sreg  <= {sreg[WORD_W-2:0], 1'b0};
        left  <= left - 1'b1;
      end
    end
  end

  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata)); // R7
  AST_CLK_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (left != '0)); // R6
endmodule

// File: rtl/sps_le_timer.sv
module sps_le_timer #(
  parameter int LE_CYCLES = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic le,
  output logic fin
);
  localparam int CW = $clog2(LE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign le  = run;
  assign fin = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(LE_CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_LE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fin && !start) |=> run); // R8
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import sps_pkg::*;
#(
  parameter int FREQ_W    = 12,
  parameter int IF_MHZ    = 2,
  parameter int REF_MIN   = 5,
  parameter int REF_MAX   = 20,
  parameter int HALF_DIV  = 8,
  parameter int LE_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_chan_mhz,
  input  logic              req_rx,
  input  logic [REF_W-1:0]  req_ref,
  output logic              syn_sclk,
  output logic              syn_sdata,
  output logic              syn_le,
  output logic              busy,
  output logic              done,
  output logic              reject
);
  localparam int LW = $clog2(WORD_MAX + 1);

  seq_state_e      state;
  logic            second;
  div_pair_t       div_hold;
  div_pair_t       calc_pair;
  logic            calc_ok;
  logic            accept;
  logic            sh_load;
  logic [WORD_MAX-1:0] sh_word;
  logic [LW-1:0]   sh_len;
  logic            tick;
  logic            last_fall;
  logic            le_fin;
  logic            done_q;
  logic            rej_q;

  assign req_ready = (state == SEQ_IDLE);
  assign busy      = (state != SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = done_q;
  assign reject    = rej_q;

  sps_divcalc #(
    .FREQ_W(FREQ_W), .IF_MHZ(IF_MHZ), .REF_MIN(REF_MIN), .REF_MAX(REF_MAX)
  ) i_calc (
    .chan(req_chan_mhz), .rx(req_rx), .ref_val(req_ref),
    .pair(calc_pair), .ok(calc_ok)
  );

  // Load the shifter with the reference word on acceptance, and with the
  // divider word when the first strobe ends.
  always_comb begin
    sh_load = 1'b0;
    sh_word = make_ref_word(req_ref);
    sh_len  = LW'(REF_WORD_W);
    if (accept && calc_ok) begin
      sh_load = 1'b1;
    end else if ((state == SEQ_STROBE) && le_fin && !second) begin
      sh_load = 1'b1;
      sh_word = make_div_word(div_hold);
      sh_len  = LW'(DIV_WORD_W);
    end
  end

  sps_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .clear(sh_load),
    .en(state == SEQ_SHIFT), .tick(tick)
  );

  sps_shifter #(.WORD_W(WORD_MAX)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_word(sh_word),
    .load_len(sh_len), .step(tick), .sclk(syn_sclk), .sdata(syn_sdata),
    .last_fall(last_fall)
  );

  sps_le_timer #(.LE_CYCLES(LE_CYCLES)) i_le (
    .clk(clk), .rst_n(rst_n), .start(last_fall), .le(syn_le), .fin(le_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      second   <= 1'b0;
      div_hold <= '0;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            if (calc_ok) begin
              state    <= SEQ_SHIFT;
              second   <= 1'b0;
              div_hold <= calc_pair;
            end else begin
              rej_q <= 1'b1;
            end
          end
        end
        SEQ_SHIFT: begin
          if (last_fall) state <= SEQ_STROBE;
        end
        SEQ_STROBE: begin
          if (le_fin) begin
            if (second) begin
              state  <= SEQ_IDLE;
              done_q <= 1'b1;
            end else begin
              state  <= SEQ_SHIFT;
              second <= 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    syn_le |-> !syn_sclk); // R8
  AST_DONE_AFTER_LE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(syn_le) && !busy)); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && !syn_le && !syn_sclk)); // R2
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!syn_sclk && !syn_le)); // R6
  AST_DIV_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && calc_ok) |->
      ((FREQ_W+1)'({calc_pair.n, calc_pair.a}) ==
       (FREQ_W+1)'(req_rx ? (req_chan_mhz - FREQ_W'(IF_MHZ)) : req_chan_mhz))); // R4
endmodule

// File: tb/test_synth_prog_seq.sv
`timescale 1ns/1ps
module test_synth_prog_seq;
  localparam int HALF  = 8;
  localparam int LEC   = 13;
  localparam int TOTAL = 38*HALF + 2*LEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [11:0] req_chan_mhz = '0;
  logic req_rx = 1'b0;
  logic [4:0] req_ref = '0;
  logic syn_sclk, syn_sdata, syn_le, busy, done, reject;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  synth_prog_seq #(.HALF_DIV(HALF), .LE_CYCLES(LEC)) i_synth_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan_mhz(req_chan_mhz), .req_rx(req_rx), .req_ref(req_ref),
    .syn_sclk(syn_sclk), .syn_sdata(syn_sdata), .syn_le(syn_le),
    .busy(busy), .done(done), .reject(reject)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model and bus decoder
  int left = 0;
  bit done_e = 0, rej_e = 0;
  int exp_val[$];
  int exp_len[$];
  bit p_sclk = 0, p_le = 0, p_data = 0;
  int run_len = 0, le_len = 0, acc = 0, nbits = 0;

  function automatic bit req_ok(int c, bit rx, int r);
    return (r >= 5) && (r <= 20) && !(rx && c < 2);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 ready", req_ready, left == 0);
      chk("R9 busy", busy, left > 0);
      chk("R9 done", done, done_e);
      chk("R2 reject", reject, rej_e);
      if (syn_sclk != p_sclk) begin
        if (syn_sclk) begin
          if (nbits > 0) chk("R6 low half", run_len, HALF);
          acc = (acc << 1) | syn_sdata;
          nbits++;
        end else begin
          chk("R6 high half", run_len, HALF);
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      if (syn_sclk && p_sclk) chk("R7 data steady", syn_sdata, p_data);
      if (syn_le) chk("R8 clk low in strobe", syn_sclk, 0);
      if (syn_le && !p_le) begin
        if (exp_val.size() == 0) begin
          chk("R5 unexpected word", 1, 0);
        end else begin
          chk("R5 word bits", nbits, exp_len.pop_front());
          chk("R5 word value", acc, exp_val.pop_front());
        end
        acc = 0; nbits = 0; le_len = 1;
      end else if (syn_le) begin
        le_len++;
      end
      if (!syn_le && p_le) chk("R8 strobe width", le_len, LEC);
      p_sclk = syn_sclk; p_le = syn_le; p_data = syn_sdata;
      // advance model to the next edge
      done_e = (left == 1);
      rej_e  = 0;
      if (left > 0) begin
        left--;
      end else if (req_valid) begin
        if (req_ok(req_chan_mhz, req_rx, req_ref)) begin
          int lo;
          lo = req_rx ? req_chan_mhz - 2 : req_chan_mhz;
          left = TOTAL;
          exp_val.push_back(32 + req_ref); exp_len.push_back(6);
          exp_val.push_back(lo);           exp_len.push_back(13);
        end else begin
          rej_e = 1;
        end
      end
    end
  end

  task automatic issue(input int c, input bit rx, input int r);
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_chan_mhz = 12'(c); req_rx = rx; req_ref = 5'(r);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (busy || left > 0) begin @(posedge clk); #1; end
    repeat (4) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ready", req_ready, 1);
    chk("R9 reset busy", busy, 0);
    chk("R6 reset sclk", syn_sclk, 0);
    chk("R8 reset le", syn_le, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R3 R4 R5: transmit and receive splits
    issue(2402, 0, 16); settle();
    issue(2402, 1, 13); settle();
    issue(2399, 0, 5);  settle();   // A = 31, R at lower bound
    issue(2500, 1, 20); settle();   // R at upper bound
    issue(2, 1, 12);    settle();   // R3 oscillator frequency 0
    // R2 R3 rejections
    issue(2402, 0, 4);  settle();
    issue(2402, 0, 21); settle();
    issue(100, 0, 0);   settle();
    issue(2401, 0, 31); settle();
    issue(1, 1, 12);    settle();
    // R1 request pulsed while busy is ignored
    issue(2440, 0, 12);
    repeat (50) @(posedge clk); #1;
    req_valid = 1'b1; req_chan_mhz = 12'd2470; req_ref = 5'd9;
    @(posedge clk); #1;
    req_valid = 1'b0;
    settle();
    // R9 back-to-back: second request taken in the done cycle
    issue(2410, 0, 7);
    issue(2411, 1, 8);
    settle();
    chk("R1 R5 no pending words", exp_val.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule